// File: doc/BRIEF.md
# Video Controller CPU Register Front End

This block sits between a CPU bus and the internals of a tile-based video controller. The CPU sees eight byte-wide registers. They repeat every eight bytes across the decoded window, so only the three lowest address bits pick a register. Through them the CPU sets control and mask bits and reads a status byte. It loads a horizontal and a vertical scroll value and sets a VRAM pointer in two writes. It moves data to and from VRAM through a data port that advances the pointer after each access. Sprite memory is loaded through an address port and a data port.

The VRAM and sprite memory are outside the block, reached over plain read and write ports. An external frame-timing source pulses the start and end of vertical blank and reports sprite-0 collisions. The block combines the vertical-blank flag with an enable bit to drive a level interrupt request.

Top module: `vrf_top`

## Requirements
- R1: A register is selected by cpu_addr[2:0] alone. Every higher address bit is ignored, so an access at any mirror behaves the same as an access at the base.
- R2: Writing register 0 sets the control byte. Bit 7 is the interrupt enable, bit 5 drives spr_tall, bit 2 picks the VRAM step, and bits 1:0 drive nt_base.
- R3: Writing register 1 stores a byte that appears on mask_q after the write edge.
- R4: A read of register 2 returns the vertical-blank flag in bit 7 and the sprite-0 flag in bit 6, with bits 5:0 zero. A frame_start pulse sets the vertical-blank flag. A spr0_hit pulse sets the sprite-0 flag. A frame_end pulse clears both flags.
- R5: A read of register 2 clears the vertical-blank flag and the shared write toggle. The read returns the value held before the edge. If frame_start comes in the same cycle as the read, the flag ends set.
- R6: Two writes to register 6 form the VRAM pointer, high byte first and then low byte. The pointer is VAW bits wide (14 by default), so high-byte bits above it are dropped.
- R7: Two writes to register 5 load scroll_x and then scroll_y. Registers 5 and 6 share a single toggle, so a first write to either one makes the next write to either one the second write.
- R8: An access to register 7 does one of two things. A write drives vram_we with vram_addr equal to the pointer and vram_wdata equal to the CPU byte. A read returns vram_rdata. After either access the pointer grows by 1 when control bit 2 is 0 and by 32 when it is 1, modulo 2^VAW.
- R9: A write to register 3 sets the sprite address. A write to register 4 drives oam_we at that address and then adds 1 to the address, modulo 256.
- R10: irq is high exactly while the vertical-blank flag and control bit 7 are both set.
- R11: After reset all registers, flags, the toggle and the pointer are zero. Reads of registers 0, 1, 3, 4, 5 and 6 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register window selected |
| cpu_we | input | 1 | Write strobe |
| cpu_re | input | 1 | Read strobe |
| cpu_addr | input | AW | CPU address within the mirrored window |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the cycle of the read |
| frame_start | input | 1 | Pulse at the start of vertical blank |
| frame_end | input | 1 | Pulse at the end of vertical blank |
| spr0_hit | input | 1 | Pulse on sprite-0 collision |
| vram_addr | output | VAW | VRAM pointer |
| vram_we | output | 1 | VRAM write enable |
| vram_wdata | output | 8 | VRAM write data |
| vram_rdata | input | 8 | VRAM read data at vram_addr |
| oam_addr | output | 8 | Sprite memory address |
| oam_we | output | 1 | Sprite memory write enable |
| oam_wdata | output | 8 | Sprite memory write data |
| scroll_x | output | 8 | Horizontal scroll |
| scroll_y | output | 8 | Vertical scroll |
| spr_tall | output | 1 | Tall sprite select |
| nt_base | output | 2 | Base nametable select |
| mask_q | output | 8 | Mask register |
| irq | output | 1 | Vertical-blank interrupt request |

## Verification
The collision that matters is a status read landing in the same cycle as a frame_start pulse. The read-clear and the external set then compete for the vertical-blank flag. The bench forces this case directly. It also pulses frame_start at random during random register traffic, so the collision recurs. In each case the read data must show the flag as it was before the edge, and the flag and irq must come out set afterwards. A second overlap, where a status read lands between the two writes of the scroll or pointer sequence, checks that the shared toggle restarts.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  typedef enum logic [2:0] {
    RG_CTRL = 3'd0, RG_MASK = 3'd1, RG_STAT = 3'd2, RG_SADR = 3'd3,
    RG_SDAT = 3'd4, RG_SCRL = 3'd5, RG_VADR = 3'd6, RG_VDAT = 3'd7
  } reg_idx_e;

  localparam int CB_IRQ_EN = 7;
  localparam int CB_TALL   = 5;
  localparam int CB_INC    = 2;

  function automatic logic [15:0] ptr_step(input logic inc32);
    return inc32 ? 16'd32 : 16'd1;
  endfunction

  function automatic logic [7:0] stat_byte(input logic vbl, input logic hit);
    return {vbl, hit, 6'b0};
  endfunction
endpackage

// File: rtl/vrf_decode.sv
module vrf_decode #(
  parameter int AW = 13
) (
  input  logic          sel,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  output logic [7:0]    wr_stb,
  output logic [7:0]    rd_stb
);
  logic [AW-1:0] unused_addr;
  assign unused_addr = {addr[AW-1:3], 3'b0};

  for (genvar g = 0; g < 8; g++) begin : g_reg
    assign wr_stb[g] = sel & we & (addr[2:0] == 3'(g));
    assign rd_stb[g] = sel & re & ~we & (addr[2:0] == 3'(g));
  end
endmodule

// File: rtl/vrf_latch2.sv
module vrf_latch2 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_scroll,
  input  logic       wr_addr,
  input  logic       clr_toggle,
  input  logic [7:0] wdata,
  output logic [7:0] scroll_x,
  output logic [7:0] scroll_y,
  output logic       ld_hi,
  output logic       ld_lo
);
  logic toggle;

  assign ld_hi = wr_addr & ~toggle;
  assign ld_lo = wr_addr & toggle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle   <= 1'b0;
      scroll_x <= '0;
      scroll_y <= '0;
    end else begin
      if (wr_scroll && !toggle) scroll_x <= wdata;
      if (wr_scroll && toggle)  scroll_y <= wdata;
      if (clr_toggle)                 toggle <= 1'b0;
      else if (wr_scroll || wr_addr)  toggle <= ~toggle;
    end
  end

  AST_TOGGLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_toggle |=> !toggle); // R5
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_scroll || wr_addr) && !clr_toggle |=> toggle != $past(toggle)); // R7
endmodule

// File: rtl/vrf_vptr.sv
module vrf_vptr #(
  parameter int VAW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_hi,
  input  logic           ld_lo,
  input  logic           data_acc,
  input  logic           inc32,
  input  logic [VAW-9:0] hi_bits,
  input  logic [7:0]     lo_bits,
  output logic [VAW-1:0] ptr
);
  import vrf_pkg::*;

  logic [15:0] step;
  assign step = ptr_step(inc32);

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (ld_hi)    ptr[VAW-1:8] <= hi_bits;
    else if (ld_lo)    ptr[7:0] <= lo_bits;
    else if (data_acc) ptr <= ptr + step[VAW-1:0];
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hi || ld_lo || data_acc) |=> $stable(ptr)); // R8
  AST_PTR_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> ptr[VAW-1:8] == $past(ptr[VAW-1:8])); // R6
endmodule

// File: rtl/vrf_status.sv
module vrf_status (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic frame_end,
  input  logic spr0_hit,
  input  logic stat_rd,
  output logic vblank,
  output logic hit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vblank <= 1'b0;
      hit    <= 1'b0;
    end else begin
      if (frame_start)            vblank <= 1'b1;
      else if (stat_rd || frame_end) vblank <= 1'b0;
      if (spr0_hit)       hit <= 1'b1;
      else if (frame_end) hit <= 1'b0;
    end
  end

  AST_VBL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> vblank); // R4
  AST_RD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !frame_start |=> !vblank); // R5
endmodule

// File: rtl/vrf_top.sv
module vrf_top #(
  parameter int AW  = 13,
  parameter int VAW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_sel,
  input  logic           cpu_we,
  input  logic           cpu_re,
  input  logic [AW-1:0]  cpu_addr,
  input  logic [7:0]     cpu_wdata,
  output logic [7:0]     cpu_rdata,
  input  logic           frame_start,
  input  logic           frame_end,
  input  logic           spr0_hit,
  output logic [VAW-1:0] vram_addr,
  output logic           vram_we,
  output logic [7:0]     vram_wdata,
  input  logic [7:0]     vram_rdata,
  output logic [7:0]     oam_addr,
  output logic           oam_we,
  output logic [7:0]     oam_wdata,
  output logic [7:0]     scroll_x,
  output logic [7:0]     scroll_y,
  output logic           spr_tall,
  output logic [1:0]     nt_base,
  output logic [7:0]     mask_q,
  output logic           irq
);
  import vrf_pkg::*;

  logic [7:0] wr_stb, rd_stb;
  logic [7:0] ctrl_q;
  logic       ld_hi, ld_lo, data_acc, vblank, hit;
  logic [7:0] unused_bits;

  assign unused_bits = {rd_stb[6:3], rd_stb[1:0], ctrl_q[6] ^ ctrl_q[4], ctrl_q[3]};

  vrf_decode #(.AW(AW)) u_dec (
    .sel(cpu_sel), .we(cpu_we), .re(cpu_re), .addr(cpu_addr),
    .wr_stb(wr_stb), .rd_stb(rd_stb)
  );

  vrf_latch2 u_latch (
    .clk(clk), .rst_n(rst_n),
    .wr_scroll(wr_stb[RG_SCRL]), .wr_addr(wr_stb[RG_VADR]),
    .clr_toggle(rd_stb[RG_STAT]), .wdata(cpu_wdata),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .ld_hi(ld_hi), .ld_lo(ld_lo)
  );

  assign data_acc = wr_stb[RG_VDAT] | rd_stb[RG_VDAT];

  vrf_vptr #(.VAW(VAW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .data_acc(data_acc), .inc32(ctrl_q[CB_INC]),
    .hi_bits(cpu_wdata[VAW-9:0]), .lo_bits(cpu_wdata), .ptr(vram_addr)
  );

  vrf_status u_stat (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .spr0_hit(spr0_hit), .stat_rd(rd_stb[RG_STAT]), .vblank(vblank), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      mask_q   <= '0;
      oam_addr <= '0;
    end else begin
      if (wr_stb[RG_CTRL]) ctrl_q <= cpu_wdata;
      if (wr_stb[RG_MASK]) mask_q <= cpu_wdata;
      if (wr_stb[RG_SADR])      oam_addr <= cpu_wdata;
      else if (wr_stb[RG_SDAT]) oam_addr <= oam_addr + 8'd1;
    end
  end

  assign spr_tall   = ctrl_q[CB_TALL];
  assign nt_base    = ctrl_q[1:0];
  assign irq        = vblank & ctrl_q[CB_IRQ_EN];
  assign vram_we    = wr_stb[RG_VDAT];
  assign vram_wdata = cpu_wdata;
  assign oam_we     = wr_stb[RG_SDAT];
  assign oam_wdata  = cpu_wdata;

  always_comb begin
    cpu_rdata = '0;
    if (rd_stb[RG_STAT]) cpu_rdata = stat_byte(vblank, hit);
    if (rd_stb[RG_VDAT]) cpu_rdata = vram_rdata;
  end

  AST_OAM_INC: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |=> oam_addr == $past(oam_addr) + 8'd1); // R9
  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(frame_start) || $past(wr_stb[RG_CTRL])); // R10
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_we, oam_we, rd_stb[RG_STAT]})); // R1
endmodule

// File: tb/vrf_top_tb_top.sv
module vrf_top_tb_top;
  localparam int AW = 13, VAW = 14;
  logic clk = 0, rst_n = 0;
  logic cpu_sel = 0, cpu_we = 0, cpu_re = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic frame_start = 0, frame_end = 0, spr0_hit = 0;
  logic [VAW-1:0] vram_addr;
  logic vram_we, oam_we, spr_tall, irq;
  logic [7:0] vram_wdata, vram_rdata, oam_addr, oam_wdata, scroll_x, scroll_y, mask_q;
  logic [1:0] nt_base;

  int checks = 0, errors = 0;
  // bench model
  logic [7:0] m_ctrl = 0, m_mask = 0, m_oam = 0, m_sx = 0, m_sy = 0;
  logic [VAW-1:0] m_ptr = 0;
  logic m_tog = 0, m_vbl = 0, m_hit = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] vfn(input logic [VAW-1:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction
  assign vram_rdata = vfn(vram_addr);

  vrf_top #(.AW(AW), .VAW(VAW)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state();
    chk("R2 spr_tall", spr_tall, m_ctrl[5]);
    chk("R2 nt_base", nt_base, m_ctrl[1:0]);
    chk("R3 mask", mask_q, m_mask);
    chk("R7 scroll_x", scroll_x, m_sx);
    chk("R7 scroll_y", scroll_y, m_sy);
    chk("R6 R8 pointer", vram_addr, m_ptr);
    chk("R9 oam_addr", oam_addr, m_oam);
    chk("R10 irq", irq, m_ctrl[7] & m_vbl);
  endtask

  // one bus cycle; hi = mirror bits, fs/fe/hp = frame pulses in the same cycle
  task automatic op(input logic [2:0] idx, input logic [AW-4:0] hi, input logic we,
                    input logic [7:0] wd, input logic fs, input logic fe, input logic hp);
    logic [7:0] exp_rd;
    @(negedge clk);
    cpu_sel = 1; cpu_we = we; cpu_re = ~we; cpu_addr = {hi, idx}; cpu_wdata = wd;
    frame_start = fs; frame_end = fe; spr0_hit = hp;
    #4;
    exp_rd = 8'h00;
    if (!we && idx == 3'd2) exp_rd = {m_vbl, m_hit, 6'b0};
    if (!we && idx == 3'd7) exp_rd = vfn(m_ptr);
    chk("R4 R8 R11 rdata", cpu_rdata, exp_rd);
    chk("R8 vram_we", vram_we, we && idx == 3'd7);
    chk("R9 oam_we", oam_we, we && idx == 3'd4);
    if (we && idx == 3'd7) chk("R8 vram_wdata", vram_wdata, wd);
    if (we && idx == 3'd4) begin
      chk("R9 oam_wdata", oam_wdata, wd);
      chk("R9 oam write addr", oam_addr, m_oam);
    end
    // model update
    if (we) begin
      case (idx)
        3'd0: m_ctrl = wd;
        3'd1: m_mask = wd;
        3'd3: m_oam = wd;
        3'd4: m_oam = m_oam + 8'd1;
        3'd5: begin if (m_tog) m_sy = wd; else m_sx = wd; m_tog = ~m_tog; end
        3'd6: begin
          if (m_tog) m_ptr[7:0] = wd; else m_ptr[13:8] = wd[5:0];
          m_tog = ~m_tog;
        end
        3'd7: m_ptr = m_ptr + (m_ctrl[2] ? 14'd32 : 14'd1);
        default: ;
      endcase
    end else begin
      if (idx == 3'd2) begin m_vbl = 0; m_tog = 0; end
      if (idx == 3'd7) m_ptr = m_ptr + (m_ctrl[2] ? 14'd32 : 14'd1);
    end
    if (fe) begin m_vbl = 0; m_hit = 0; end
    if (fs) m_vbl = 1;
    if (hp) m_hit = 1;
    @(posedge clk); #1;
    cpu_sel = 0; cpu_we = 0; cpu_re = 0; frame_start = 0; frame_end = 0; spr0_hit = 0;
    chk_state();
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expected=done actual=hung");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    chk_state(); // R11 reset values
    op(3'd2, 10'h000, 0, 0, 0, 0, 0); // R11 status zero after reset
    op(3'd1, 10'h000, 0, 0, 0, 0, 0); // R11 non-readable register
    // R1 R2 control via mirror
    op(3'd0, 10'h3A5, 1, 8'hA7, 0, 0, 0);
    op(3'd1, 10'h011, 1, 8'h5C, 0, 0, 0); // R3
    // R6 pointer two writes with high bits dropped
    op(3'd6, 10'h2F0, 1, 8'hFF, 0, 0, 0);
    op(3'd6, 10'h001, 1, 8'hF0, 0, 0, 0);
    // R8 step 32 (ctrl bit2=1) wraps
    op(3'd7, 10'h000, 1, 8'h11, 0, 0, 0);
    op(3'd7, 10'h100, 0, 8'h00, 0, 0, 0);
    op(3'd0, 10'h000, 1, 8'h80, 0, 0, 0); // step 1, irq enable
    op(3'd7, 10'h000, 0, 8'h00, 0, 0, 0);
    // R7 shared toggle, R5 status read restarts it
    op(3'd5, 10'h000, 1, 8'h12, 0, 0, 0);
    op(3'd2, 10'h000, 0, 8'h00, 0, 0, 0);
    op(3'd5, 10'h000, 1, 8'h34, 0, 0, 0);
    op(3'd6, 10'h000, 1, 8'h07, 0, 0, 0); // second write: low byte
    // R9 sprite address wrap
    op(3'd3, 10'h000, 1, 8'hFF, 0, 0, 0);
    op(3'd4, 10'h055, 1, 8'hC3, 0, 0, 0);
    op(3'd4, 10'h000, 1, 8'h3C, 0, 0, 0);
    // R4 R10 flags
    op(3'd1, 10'h000, 1, 8'h00, 1, 0, 1);
    op(3'd2, 10'h000, 0, 8'h00, 0, 0, 0);
    op(3'd1, 10'h000, 1, 8'h00, 1, 0, 0);
    // R5 collision: status read with frame_start
    op(3'd2, 10'h000, 0, 8'h00, 1, 0, 0);
    op(3'd2, 10'h000, 0, 8'h00, 0, 0, 0);
    op(3'd1, 10'h000, 1, 8'h00, 0, 1, 0); // R4 frame_end clears
    op(3'd2, 10'h000, 0, 8'h00, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 600; i++) begin
      logic [2:0] idx;
      logic we, fs, fe, hp;
      idx = 3'($urandom_range(0, 7));
      we  = ($urandom_range(0, 2) != 0);
      if (idx == 3'd2) we = ($urandom_range(0, 3) == 0);
      fs = ($urandom_range(0, 9) == 0);
      fe = !fs && ($urandom_range(0, 14) == 0);
      hp = ($urandom_range(0, 11) == 0);
      op(idx, 10'($urandom), we, 8'($urandom), fs, fe, hp);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule